// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a small 32-bit processor core. It presents sixteen register numbers, 0 to 15, to the rest of the core. Behind them sit 31 physical general registers, and the processor mode picks which physical copy a register number reaches. Number 15 is the program counter and number 14 is the link register. Interrupt and exception modes get private copies of some registers, so a handler can run without saving the interrupted code's stack pointer and link register.

The block also holds the current status word and one saved status word for each privileged mode. Taking an exception is a single-cycle operation. In one clock edge the block switches the mode, saves the old status into the new mode's saved slot, and writes the return address into the new mode's link register. A separate request copies the saved status back into the current status, which returns from the handler.

Instruction decode, the ALU, exception prioritisation and memory are outside the block. The block only does the mapping and the status save and restore.

Top module: `bank_regfile`

## Requirements
- R1: Mode encodings in status bits [4:0] are user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111 and undefined 11011. Every other value is illegal, and a request that carries an illegal mode changes no state.
- R2: In fast-interrupt mode, numbers 8 to 14 reach private copies. In the interrupt, supervisor, abort and undefined modes, numbers 13 and 14 reach that mode's private pair. Every other number, in every mode, reaches the user copy. The result is 31 physical registers.
- R3: Two read ports return the mapped register combinationally for the current mode. A read of number 15 returns bits [1:0] as zero and bits [31:2] from the program counter.
- R4: When the write port is enabled, it stores wr_data into the mapped register at the next rising edge. A read of the same register in that cycle returns the old value.
- R5: A link request stores the program counter, with bits [1:0] forced to zero, into register 14 of the active mode. When a port write in the same cycle targets the same physical register, the link value wins.
- R6: An exception request names a privileged target mode. In one edge it copies the current status into that mode's saved status, sets the mode bits, keeps the flags, and writes the link value of R5 into that mode's register 14. A request naming user mode or an illegal mode is ignored, and in that case a link request in the same cycle acts normally.
- R7: A status write loads flags [31:28] and mode [4:0] from psr_wdata. All other status bits read as zero.
- R8: A restore request copies the current mode's saved status into the current status. It is ignored in user mode, and it is ignored when the saved value holds an illegal mode.
- R9: spsr_out shows the current mode's saved status. In user mode it shows the current status.
- R10: Reset is synchronous and active low. It selects supervisor mode with clear flags, and zeroes the program counter, every other register and every saved status.
- R11: When requests coincide, an accepted exception request beats a restore, and an applied restore beats a status write. The losing request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Register number, read port A |
| rd_b_idx | input | 4 | Register number, read port B |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| lnk_en | input | 1 | Copy PC into the active mode's register 14 |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode encoding for exception entry |
| ret_en | input | 1 | Restore status from the saved copy |
| psr_we | input | 1 | Status write request (mode change) |
| psr_wdata | input | 32 | Status write data: flags [31:28], mode [4:0] |
| rd_a_data | output | 32 | Read port A data |
| rd_b_data | output | 32 | Read port B data |
| cpsr_out | output | 32 | Current status |
| spsr_out | output | 32 | Saved status of the current mode |

## Verification
The read ports and spsr_out are combinational, so they reflect the state held before the next edge. Every write, link, exception entry, restore and status write takes effect at the next rising edge, one cycle after it is presented. The bench drives inputs on the falling edge and compares all four outputs against a bench model one time unit later. It then advances its model at the rising edge. Each check therefore sees the effect of stimulus presented one cycle earlier, and it also confirms that a register written in the current cycle still reads its old value.

// File: rtl/bank_pkg.sv
// Shared constants, mode encodings and mode-slot type for the banked
// register file. Assumes the fixed architectural layout: 16 register
// numbers, 31 physical registers, six modes.
package bank_pkg;

    localparam int XLEN       = 32;
    localparam int ARCH_REGS  = 16;
    localparam int IDX_W      = $clog2(ARCH_REGS);
    localparam int MODE_W     = 5;
    localparam int NUM_SLOTS  = 6;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int FIQ_FIRST  = 8;                       // first fast-interrupt banked number
    localparam int PAIR_FIRST = 13;                      // first number of a two-register bank
    localparam int FIQ_BASE   = ARCH_REGS;               // physical base of fast-interrupt bank
    localparam int PAIR_BASE  = FIQ_BASE + (ARCH_REGS - 1 - FIQ_FIRST);
    localparam int PHYS_REGS  = PAIR_BASE + 2 * (NUM_SLOTS - 2);
    localparam int PHYS_W     = $clog2(PHYS_REGS);
    localparam int FLAG_HI    = 31;
    localparam int FLAG_LO    = 28;

    localparam logic [MODE_W-1:0] ENC_USR = 5'b10000;
    localparam logic [MODE_W-1:0] ENC_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] ENC_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] ENC_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] ENC_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] ENC_UND = 5'b11011;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_USR = 3'd0,
        SLOT_FIQ = 3'd1,
        SLOT_IRQ = 3'd2,
        SLOT_SVC = 3'd3,
        SLOT_ABT = 3'd4,
        SLOT_UND = 3'd5
    } mode_slot_e;

    // True when the encoding names one of the six modes
    function automatic logic enc_valid(input logic [MODE_W-1:0] enc);
        case (enc)
            ENC_USR, ENC_FIQ, ENC_IRQ, ENC_SVC, ENC_ABT, ENC_UND: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Map a legal encoding to its slot; illegal values fold to user
    function automatic mode_slot_e enc_to_slot(input logic [MODE_W-1:0] enc);
        case (enc)
            ENC_FIQ: return SLOT_FIQ;
            ENC_IRQ: return SLOT_IRQ;
            ENC_SVC: return SLOT_SVC;
            ENC_ABT: return SLOT_ABT;
            ENC_UND: return SLOT_UND;
            default: return SLOT_USR;
        endcase
    endfunction

endpackage

// File: rtl/bank_map.sv
// Translates a register number and mode slot into a physical register
// index. Purely combinational. Assumes slot values beyond SLOT_UND never
// occur (they map to the user copies).
module bank_map
    import bank_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys
);

    int unsigned idx_i;
    int unsigned slot_i;

    // Select the shadow copy for the mode, or fall back to the user copy
    always_comb begin
        idx_i  = int'(idx);
        slot_i = int'(slot);
        phys   = PHYS_W'(idx_i);
        if (slot == SLOT_FIQ && idx_i >= FIQ_FIRST && idx_i <= ARCH_REGS - 2) begin
            phys = PHYS_W'(FIQ_BASE + idx_i - FIQ_FIRST);
        end else if (slot_i >= 2 && slot_i < NUM_SLOTS &&
                     idx_i >= PAIR_FIRST && idx_i <= ARCH_REGS - 2) begin
            phys = PHYS_W'(PAIR_BASE + 2 * (slot_i - 2) + (idx_i - PAIR_FIRST));
        end
    end

endmodule

// File: rtl/bank_gpr_store.sv
// Physical storage for the general registers: two combinational read
// ports, one port write and one link write. The link write wins when both
// hit the same entry. Assumes indices are below DEPTH.
module bank_gpr_store #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 31,
    localparam int AW   = $clog2(DEPTH),
    localparam int PC_N = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_we,
    input  logic [AW-1:0]   port_phys,
    input  logic [XLEN-1:0] port_data,
    input  logic            lnk_we,
    input  logic [AW-1:0]   lnk_phys,
    input  logic [XLEN-1:0] lnk_data,
    input  logic [AW-1:0]   rd_a_phys,
    input  logic [AW-1:0]   rd_b_phys,
    output logic [XLEN-1:0] rd_a_q,
    output logic [XLEN-1:0] rd_b_q,
    output logic [XLEN-1:0] pc_q
);

    logic [XLEN-1:0] regs_q [DEPTH];

    // Update storage; the later link assignment overrides a port write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
        end else begin
            if (port_we) regs_q[port_phys] <= port_data;
            if (lnk_we)  regs_q[lnk_phys]  <= lnk_data;
        end
    end

    // Combinational reads return the value held before the edge
    always_comb begin
        rd_a_q = regs_q[rd_a_phys];
        rd_b_q = regs_q[rd_b_phys];
        pc_q   = regs_q[PC_N];
    end

    AST_LINK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_we && port_we && lnk_phys == port_phys) |=>
            regs_q[$past(lnk_phys)] == $past(lnk_data)); // R5

    AST_PORT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && !(lnk_we && lnk_phys == port_phys)) |=>
            regs_q[$past(port_phys)] == $past(port_data)); // R4

endmodule

// File: rtl/bank_psr_unit.sv
// Holds the current status and one saved status per privileged mode.
// Performs exception entry, restore and status write with fixed
// priority, and rejects illegal modes. Assumes a single request is
// honoured per cycle.
module bank_psr_unit
    import bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_en,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic              ret_en,
    input  logic              psr_we,
    input  logic [XLEN-1:0]   psr_wdata,
    output logic [XLEN-1:0]   cpsr_q,
    output logic [XLEN-1:0]   spsr_view,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              exc_take,
    output logic [SLOT_W-1:0] exc_slot
);

    localparam int NSAVED = NUM_SLOTS - 1;

    logic [XLEN-1:0] spsr_q [1:NSAVED];
    logic [XLEN-1:0] saved_cur;
    logic            ret_take;
    logic            wr_take;
    logic [XLEN-1:0] wr_clean;

    // Decode the current mode and judge each request
    always_comb begin
        cur_slot  = enc_to_slot(cpsr_q[MODE_W-1:0]);
        exc_slot  = enc_to_slot(exc_mode);
        exc_take  = exc_en && enc_valid(exc_mode) && exc_mode != ENC_USR;
        saved_cur = (cur_slot == SLOT_USR) ? cpsr_q : spsr_q[int'(cur_slot)];
        ret_take  = !exc_take && ret_en && cur_slot != SLOT_USR &&
                    enc_valid(saved_cur[MODE_W-1:0]);
        wr_take   = !exc_take && !ret_take && psr_we &&
                    enc_valid(psr_wdata[MODE_W-1:0]);
        wr_clean  = '0;
        wr_clean[FLAG_HI:FLAG_LO] = psr_wdata[FLAG_HI:FLAG_LO];
        wr_clean[MODE_W-1:0]      = psr_wdata[MODE_W-1:0];
        spsr_view = saved_cur;
    end

    // Current status register: entry, restore or write, in priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_q <= {{(XLEN-MODE_W){1'b0}}, ENC_SVC};
        end else if (exc_take) begin
            cpsr_q[MODE_W-1:0] <= exc_mode;
        end else if (ret_take) begin
            cpsr_q <= saved_cur;
        end else if (wr_take) begin
            cpsr_q <= wr_clean;
        end
    end

    // Saved status registers: the old current status lands on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= NSAVED; i++) spsr_q[i] <= '0;
        end else if (exc_take) begin
            spsr_q[int'(exc_slot)] <= cpsr_q;
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid(cpsr_q[MODE_W-1:0])); // R1

    AST_ILLEGAL_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_we && !enc_valid(psr_wdata[MODE_W-1:0]) && !exc_en && !ret_en) |=>
            $stable(cpsr_q)); // R1

    AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (spsr_q[int'($past(exc_slot))] == $past(cpsr_q) &&
                      cpsr_q[MODE_W-1:0] == $past(exc_mode))); // R6

    AST_USER_RESTORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !exc_en && !psr_we && cur_slot == SLOT_USR) |=> $stable(cpsr_q)); // R8

endmodule

// File: rtl/bank_regfile.sv
// Top of the mode-banked register file. Maps register numbers through the
// current mode, routes the write, link and exception-entry updates, and
// masks the low bits of the program counter on reads. Assumes the core
// raises at most one exception request per cycle.
module bank_regfile
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              lnk_en,
    input  logic              exc_en,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic              ret_en,
    input  logic              psr_we,
    input  logic [XLEN-1:0]   psr_wdata,
    output logic [XLEN-1:0]   rd_a_data,
    output logic [XLEN-1:0]   rd_b_data,
    output logic [XLEN-1:0]   cpsr_out,
    output logic [XLEN-1:0]   spsr_out
);

    localparam int NLOOK  = 4;              // read A, read B, write, link
    localparam int LK_RDA = 0;
    localparam int LK_RDB = 1;
    localparam int LK_WR  = 2;
    localparam int LK_LNK = 3;
    localparam logic [IDX_W-1:0] PC_IDX  = IDX_W'(ARCH_REGS - 1);
    localparam logic [IDX_W-1:0] LNK_IDX = IDX_W'(ARCH_REGS - 2);

    logic [SLOT_W-1:0] cur_slot;
    logic [SLOT_W-1:0] exc_slot;
    logic              exc_take;
    logic [XLEN-1:0]   cpsr_q;
    logic [XLEN-1:0]   spsr_view;
    logic [SLOT_W-1:0] lk_slot [NLOOK];
    logic [IDX_W-1:0]  lk_idx  [NLOOK];
    logic [PHYS_W-1:0] lk_phys [NLOOK];
    logic [XLEN-1:0]   raw_a;
    logic [XLEN-1:0]   raw_b;
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   lnk_data;
    logic              lnk_we;

    bank_psr_unit #(.XLEN(XLEN)) u_psr (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_en    (exc_en),
        .exc_mode  (exc_mode),
        .ret_en    (ret_en),
        .psr_we    (psr_we),
        .psr_wdata (psr_wdata),
        .cpsr_q    (cpsr_q),
        .spsr_view (spsr_view),
        .cur_slot  (cur_slot),
        .exc_take  (exc_take),
        .exc_slot  (exc_slot)
    );

    // Gather the lookup requests; the link target follows an accepted entry
    always_comb begin
        lk_slot[LK_RDA] = cur_slot;
        lk_idx[LK_RDA]  = rd_a_idx;
        lk_slot[LK_RDB] = cur_slot;
        lk_idx[LK_RDB]  = rd_b_idx;
        lk_slot[LK_WR]  = cur_slot;
        lk_idx[LK_WR]   = wr_idx;
        lk_slot[LK_LNK] = exc_take ? exc_slot : cur_slot;
        lk_idx[LK_LNK]  = LNK_IDX;
    end

    for (genvar g = 0; g < NLOOK; g++) begin : g_map
        bank_map u_map (
            .slot (lk_slot[g]),
            .idx  (lk_idx[g]),
            .phys (lk_phys[g])
        );
    end

    // Link value is the word-aligned program counter
    always_comb begin
        lnk_data = {pc_q[XLEN-1:2], 2'b00};
        lnk_we   = exc_take || lnk_en;
    end

    bank_gpr_store #(.XLEN(XLEN), .DEPTH(PHYS_REGS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_we   (wr_en),
        .port_phys (lk_phys[LK_WR]),
        .port_data (wr_data),
        .lnk_we    (lnk_we),
        .lnk_phys  (lk_phys[LK_LNK]),
        .lnk_data  (lnk_data),
        .rd_a_phys (lk_phys[LK_RDA]),
        .rd_b_phys (lk_phys[LK_RDB]),
        .rd_a_q    (raw_a),
        .rd_b_q    (raw_b),
        .pc_q      (pc_q)
    );

    // Drive the outputs, hiding the low program-counter bits
    always_comb begin
        rd_a_data = (rd_a_idx == PC_IDX) ? {raw_a[XLEN-1:2], 2'b00} : raw_a;
        rd_b_data = (rd_b_idx == PC_IDX) ? {raw_b[XLEN-1:2], 2'b00} : raw_b;
        cpsr_out  = cpsr_q;
        spsr_out  = spsr_view;
    end

    AST_PC_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == PC_IDX) |-> (rd_a_data[1:0] == 2'b00 &&
                                  rd_a_data[XLEN-1:2] == pc_q[XLEN-1:2])); // R3

    AST_LINK_FOLLOWS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (lk_phys[LK_LNK] != lk_phys[LK_RDA] || cur_slot == exc_slot ||
                      rd_a_idx != LNK_IDX)); // R2

endmodule

// File: tb/bank_regfile_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a bench model each cycle.
module bank_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        wr_en, lnk_en, exc_en, ret_en, psr_we;
    logic [31:0] wr_data, psr_wdata;
    logic [4:0]  exc_mode;
    logic [31:0] rd_a_data, rd_b_data, cpsr_out, spsr_out;

    int checks   = 0;
    int failures = 0;
    string tag = "R10";
    bit done = 0;

    logic [31:0] m_gp [31];
    logic [31:0] m_cpsr;
    logic [31:0] m_spsr [6];

    always #4 clk = ~clk;

    bank_regfile u_bank_regfile (
        .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .lnk_en(lnk_en),
        .exc_en(exc_en), .exc_mode(exc_mode), .ret_en(ret_en), .psr_we(psr_we),
        .psr_wdata(psr_wdata), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .cpsr_out(cpsr_out), .spsr_out(spsr_out)
    );

    function automatic bit legal(input logic [4:0] e);
        return e == 5'h10 || e == 5'h11 || e == 5'h12 || e == 5'h13 ||
               e == 5'h17 || e == 5'h1B;
    endfunction

    function automatic int slot_of(input logic [4:0] e);
        case (e)
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 0;
        endcase
    endfunction

    // Physical index: user 0-15, fast bank 16-22, pairs from 23 upward
    function automatic int phys_of(input int s, input int n);
        if (s == 1 && n >= 8 && n <= 14) return 16 + n - 8;
        if (s >= 2 && (n == 13 || n == 14)) return 23 + 2 * (s - 2) + n - 13;
        return n;
    endfunction

    function automatic logic [31:0] exp_read(input int n);
        logic [31:0] v;
        v = m_gp[phys_of(slot_of(m_cpsr[4:0]), n)];
        if (n == 15) v[1:0] = 2'b00;
        return v;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; lnk_en = 0; exc_en = 0; ret_en = 0; psr_we = 0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 31; i++) m_gp[i] = '0;
        for (int i = 0; i < 6; i++) m_spsr[i] = '0;
        m_cpsr = 32'h0000_0013;
    endtask

    // Advance the model by one edge using the pre-edge state
    task automatic model_step();
        int cur, ns;
        logic [31:0] pcm, old_cpsr, saved;
        bit take, rtake;
        old_cpsr = m_cpsr;
        cur = slot_of(old_cpsr[4:0]);
        pcm = {m_gp[15][31:2], 2'b00};
        take = exc_en && legal(exc_mode) && exc_mode != 5'h10;
        ns = slot_of(exc_mode);
        if (wr_en) m_gp[phys_of(cur, int'(wr_idx))] = wr_data;
        if (take) m_gp[phys_of(ns, 14)] = pcm;
        else if (lnk_en) m_gp[phys_of(cur, 14)] = pcm;
        saved = (cur == 0) ? old_cpsr : m_spsr[cur];
        rtake = !take && ret_en && cur != 0 && legal(saved[4:0]);
        if (take) begin
            m_spsr[ns] = old_cpsr;
            m_cpsr[4:0] = exc_mode;
        end else if (rtake) begin
            m_cpsr = saved;
        end else if (psr_we && legal(psr_wdata[4:0])) begin
            m_cpsr = {psr_wdata[31:28], 23'b0, psr_wdata[4:0]};
        end
    endtask

    // Check outputs before the edge, then clock and update the model
    task automatic cycle();
        int cur;
        #1;
        cur = slot_of(m_cpsr[4:0]);
        chk("rd_a", rd_a_data, exp_read(int'(rd_a_idx)));
        chk("rd_b", rd_b_data, exp_read(int'(rd_b_idx)));
        chk("cpsr", cpsr_out, m_cpsr);
        chk("spsr", spsr_out, (cur == 0) ? m_cpsr : m_spsr[cur]);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input int n, input logic [31:0] d);
        idle(); wr_en = 1; wr_idx = 4'(n); wr_data = d; cycle(); idle();
    endtask

    task automatic setpsr(input logic [31:0] d);
        idle(); psr_we = 1; psr_wdata = d; cycle(); idle();
    endtask

    task automatic readpair(input int a, input int b);
        idle(); rd_a_idx = 4'(a); rd_b_idx = 4'(b); cycle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] modes [8];
        void'($urandom(32'd1234));
        modes[0] = 5'h10; modes[1] = 5'h11; modes[2] = 5'h12; modes[3] = 5'h13;
        modes[4] = 5'h17; modes[5] = 5'h1B; modes[6] = 5'h00; modes[7] = 5'h1F;
        idle(); rd_a_idx = 0; rd_b_idx = 15; wr_idx = 0; wr_data = 0;
        exc_mode = 5'h13; psr_wdata = 0; rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R10: reset state, supervisor mode, PC zero
        tag = "R10"; readpair(15, 14);

        // R4: fill registers in supervisor mode; same-cycle read sees old value
        tag = "R4";
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); wr(i, $urandom());
        end
        for (int i = 0; i < 16; i += 2) readpair(i, i + 1);

        // R3: program counter low bits hidden on both ports
        tag = "R3"; wr(15, 32'hDEAD_BEEF); readpair(15, 15);

        // R7: move to fast-interrupt mode with flags set
        tag = "R7"; setpsr(32'hF0FF_FF11); readpair(0, 1);
        // R2: fast-interrupt bank for 8..14
        tag = "R2";
        for (int i = 8; i < 15; i++) wr(i, 32'hF100_0000 + i);
        for (int i = 7; i < 16; i++) readpair(i, 22 - i > 15 ? 8 : 22 - i);
        setpsr(32'h0000_0010);
        for (int i = 7; i < 16; i++) readpair(i, 13);
        // R1: illegal mode in a status write is ignored
        tag = "R1"; setpsr(32'h5000_0015); readpair(13, 14);
        setpsr(32'h5000_0000); readpair(13, 14);

        // R5: link write beats port write to the same register 14
        tag = "R5"; wr(15, 32'h0000_1237);
        idle(); lnk_en = 1; wr_en = 1; wr_idx = 14; wr_data = 32'hAAAA_5555; cycle();
        readpair(14, 15);

        // R6: exception entry into interrupt mode from user
        tag = "R6"; idle(); exc_en = 1; exc_mode = 5'h12; cycle();
        readpair(14, 13);
        // R6/R1: illegal and user targets are ignored, link still acts
        idle(); exc_en = 1; exc_mode = 5'h1F; lnk_en = 1; cycle(); readpair(14, 0);
        idle(); exc_en = 1; exc_mode = 5'h10; cycle(); readpair(14, 0);

        // R9/R8: restore to user, then restore in user is ignored
        tag = "R8"; idle(); ret_en = 1; cycle(); readpair(14, 13);
        tag = "R9"; idle(); ret_en = 1; cycle(); readpair(14, 13);

        // R11: entry beats restore and status write in the same cycle
        tag = "R11"; idle(); exc_en = 1; exc_mode = 5'h17; ret_en = 1; psr_we = 1;
        psr_wdata = 32'h2000_0011; cycle(); readpair(14, 13);
        idle(); ret_en = 1; psr_we = 1; psr_wdata = 32'h8000_0012; cycle();
        readpair(0, 14);
        // R8: restore ignored when saved status holds an illegal mode (undefined never entered)
        setpsr(32'h0000_001B); idle(); ret_en = 1; cycle(); readpair(13, 14);

        // R2/R3: constrained random traffic
        tag = "R2";
        for (int k = 0; k < 3000; k++) begin
            int r;
            idle();
            rd_a_idx = 4'($urandom_range(0, 15));
            rd_b_idx = 4'($urandom_range(0, 15));
            wr_en = ($urandom_range(0, 1) == 1);
            wr_idx = 4'($urandom_range(0, 15));
            wr_data = $urandom();
            lnk_en = ($urandom_range(0, 9) == 0);
            r = $urandom_range(0, 99);
            exc_en = (r < 6);
            ret_en = (r >= 6 && r < 12) || (r < 2);
            psr_we = (r >= 12 && r < 20) || (r == 3);
            exc_mode = modes[$urandom_range(0, 7)];
            psr_wdata = {4'($urandom()), 23'($urandom()), modes[$urandom_range(0, 7)]};
            cycle();
        end
        idle(); cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule